// File: doc/BRIEF.md
# Keyspace Range Search Controller

This block runs an exhaustive search over an inclusive range of numeric keys. It spreads the work across a parameterised array of slow iterative keystream workers. Software programs a first key, a last key and a short target keystream before the search starts. The target is obtained beforehand by XORing the opening ciphertext bytes of a captured frame with the protocol header that is known to begin every such frame.

After a `go` pulse, a central generator walks the range in ascending order. Each key goes to the next worker in round-robin order through that worker's own start strobe. While the worker computes, the controller keeps the key it was given. When the worker reports done, the first bits of its keystream are compared against the target.

On the first match, all dispatch stops and `found` is raised, and `found_key` gives the key that worker was handed. If every key in the range has been handed out and every worker has come back without a match, `exhausted` is raised instead. The array itself sits outside the block and is reached only through the worker port vectors.

Top module: `keyrange_search`

## Requirements
- R1: After reset, `found`, `exhausted` and `busy` are low and no `wk_start` bit is high.
- R2: A `go` pulse accepted while the block is not searching dispatches every key from `start_key` up to and including `end_key` exactly once, in ascending order. A range where `start_key` equals `end_key` dispatches one key.
- R3: Dispatch is round-robin: the n-th key of a search (counting from 0) goes to worker n mod NUM_WORKERS on the shared `wk_key` bus. At most one `wk_start` bit is high in any cycle, and a worker that has not yet reported done is never started again; the generator waits for it.
- R4: When a busy worker pulses `wk_done` with its `wk_stream` slice (bits [i*STREAM_W +: STREAM_W]) equal to `target`, `found` rises on the next clock edge. At that edge `found_key` takes the key that worker was given.
- R5: If several busy workers report a match in the same cycle, the worker with the lowest index wins and its key is reported.
- R6: Once `found` is set, no further `wk_start` is issued. Later matches do not change `found_key`, and `found` stays high until `clr` or a new accepted `go`.
- R7: When the last key has been dispatched and every worker has reported done without a match, `exhausted` rises and `found` stays low. The two flags are never high together.
- R8: A `clr` pulse after a search ends clears `found` and `exhausted`. A `go` pulse while `busy` is high is ignored and does not restart the generator.
- R9: `busy` is high from the edge that accepts `go` until the edge that sets `found` or `exhausted`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse; loads the range and clears the flags |
| clr | input | 1 | Clears the result flags after a search |
| start_key | input | KEY_W | First key of the inclusive range |
| end_key | input | KEY_W | Last key of the inclusive range |
| target | input | STREAM_W | Expected keystream prefix |
| wk_start | output | NUM_WORKERS | One-cycle start strobe per worker |
| wk_key | output | KEY_W | Key handed to the worker being started |
| wk_done | input | NUM_WORKERS | One-cycle completion pulse per worker |
| wk_stream | input | NUM_WORKERS*STREAM_W | Keystream prefix per worker, valid with its done pulse |
| busy | output | 1 | Search in progress |
| found | output | 1 | A matching key was found |
| found_key | output | KEY_W | Key whose keystream matched |
| exhausted | output | 1 | Range finished with no match |

## Verification
The assertions assume that `start_key` is not above `end_key`, and that the range and target stay stable from the accepted `go` until a flag is raised. They also assume that a worker pulses `wk_done` only after it has been started and only once per start. The bench's behavioural workers follow these rules: each one latches the key on its strobe and answers a fixed number of cycles later. The latencies shrink with worker index, so neighbouring workers finish together and the priority rule is exercised. The bench changes the range registers only between searches.

// File: rtl/keyrange_pkg.sv
package keyrange_pkg;

    typedef enum logic [1:0] {
        SRCH_IDLE = 2'd0,
        SRCH_RUN  = 2'd1,
        SRCH_END  = 2'd2
    } srch_state_e;

    localparam int unsigned MAX_WORKERS = 64;

    // Index of the lowest set bit; 0 when none is set.
    function automatic int unsigned lowest_set(input logic [MAX_WORKERS-1:0] v);
        int unsigned r;
        r = 0;
        for (int k = MAX_WORKERS - 1; k >= 0; k--) begin
            if (v[k]) r = k;
        end
        return r;
    endfunction

endpackage

// File: rtl/keyrange_keygen.sv
module keyrange_keygen #(
    parameter int unsigned KEY_W       = 16,
    parameter int unsigned NUM_WORKERS = 4,
    localparam int unsigned IDX_W      = (NUM_WORKERS > 1) ? $clog2(NUM_WORKERS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [KEY_W-1:0] first_key,
    input  logic [KEY_W-1:0] last_key,
    input  logic             advance,
    output logic [KEY_W-1:0] cur_key,
    output logic             spent,
    output logic [IDX_W-1:0] slot
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_key <= '0;
            spent   <= 1'b1;
            slot    <= '0;
        end else if (load) begin
            cur_key <= first_key;
            spent   <= 1'b0;
            slot    <= '0;
        end else if (advance) begin
            if (cur_key == last_key) spent <= 1'b1;
            else                     cur_key <= cur_key + 1'b1;
            if (slot == IDX_W'(NUM_WORKERS - 1)) slot <= '0;
            else                                 slot <= slot + 1'b1;
        end
    end

endmodule

// File: rtl/keyrange_match.sv
module keyrange_match
    import keyrange_pkg::*;
#(
    parameter int unsigned NUM_WORKERS = 4,
    parameter int unsigned STREAM_W    = 16,
    localparam int unsigned IDX_W      = (NUM_WORKERS > 1) ? $clog2(NUM_WORKERS) : 1
) (
    input  logic [NUM_WORKERS-1:0]          valid_done,
    input  logic [NUM_WORKERS*STREAM_W-1:0] streams,
    input  logic [STREAM_W-1:0]             target,
    output logic                            hit,
    output logic [IDX_W-1:0]                hit_idx
);

    logic [NUM_WORKERS-1:0] eq;
    logic [MAX_WORKERS-1:0] eq_wide;

    for (genvar i = 0; i < NUM_WORKERS; i++) begin : g_cmp
        assign eq[i] = valid_done[i] && (streams[i*STREAM_W +: STREAM_W] == target);
    end

    always_comb begin
        eq_wide                  = '0;
        eq_wide[NUM_WORKERS-1:0] = eq;
        hit                      = |eq;
        hit_idx                  = IDX_W'(lowest_set(eq_wide));
    end

endmodule

// File: rtl/keyrange_search.sv
module keyrange_search
    import keyrange_pkg::*;
#(
    parameter int unsigned KEY_W       = 16,
    parameter int unsigned STREAM_W    = 16,
    parameter int unsigned NUM_WORKERS = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            go,
    input  logic                            clr,
    input  logic [KEY_W-1:0]                start_key,
    input  logic [KEY_W-1:0]                end_key,
    input  logic [STREAM_W-1:0]             target,
    output logic [NUM_WORKERS-1:0]          wk_start,
    output logic [KEY_W-1:0]                wk_key,
    input  logic [NUM_WORKERS-1:0]          wk_done,
    input  logic [NUM_WORKERS*STREAM_W-1:0] wk_stream,
    output logic                            busy,
    output logic                            found,
    output logic [KEY_W-1:0]                found_key,
    output logic                            exhausted
);

    localparam int unsigned IDX_W = (NUM_WORKERS > 1) ? $clog2(NUM_WORKERS) : 1;

    srch_state_e            state_q;
    logic [NUM_WORKERS-1:0] pending_q;
    logic [KEY_W-1:0]       tag_q [NUM_WORKERS];
    logic                   found_q, exh_q;
    logic [KEY_W-1:0]       fkey_q;

    logic                   load, dispatch, spent, hit_raw, hit, running, drained;
    logic [KEY_W-1:0]       cur_key;
    logic [IDX_W-1:0]       slot, hit_idx;
    logic [NUM_WORKERS-1:0] valid_done;

    assign running    = (state_q == SRCH_RUN);
    assign load       = go && !running && (pending_q == '0);
    assign valid_done = wk_done & pending_q;
    assign hit        = hit_raw && running;
    assign dispatch   = running && !spent && !pending_q[slot] && !hit;
    assign drained    = running && spent && (pending_q == '0) && !hit;

    keyrange_keygen #(
        .KEY_W       (KEY_W),
        .NUM_WORKERS (NUM_WORKERS)
    ) u_keygen (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .first_key (start_key),
        .last_key  (end_key),
        .advance   (dispatch),
        .cur_key   (cur_key),
        .spent     (spent),
        .slot      (slot)
    );

    keyrange_match #(
        .NUM_WORKERS (NUM_WORKERS),
        .STREAM_W    (STREAM_W)
    ) u_match (
        .valid_done (valid_done),
        .streams    (wk_stream),
        .target     (target),
        .hit        (hit_raw),
        .hit_idx    (hit_idx)
    );

    for (genvar i = 0; i < NUM_WORKERS; i++) begin : g_worker
        assign wk_start[i] = dispatch && (slot == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                pending_q[i] <= 1'b0;
                tag_q[i]     <= '0;
            end else if (wk_start[i]) begin
                pending_q[i] <= 1'b1;
                tag_q[i]     <= cur_key;
            end else if (valid_done[i]) begin
                pending_q[i] <= 1'b0;
            end
        end
    end

    assign wk_key = cur_key;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SRCH_IDLE;
            found_q <= 1'b0;
            exh_q   <= 1'b0;
            fkey_q  <= '0;
        end else if (load) begin
            state_q <= SRCH_RUN;
            found_q <= 1'b0;
            exh_q   <= 1'b0;
        end else begin
            case (state_q)
                SRCH_RUN: begin
                    if (hit) begin
                        found_q <= 1'b1;
                        fkey_q  <= tag_q[hit_idx];
                        state_q <= SRCH_END;
                    end else if (drained) begin
                        exh_q   <= 1'b1;
                        state_q <= SRCH_END;
                    end
                end
                SRCH_END: begin
                    if (clr) begin
                        found_q <= 1'b0;
                        exh_q   <= 1'b0;
                        state_q <= SRCH_IDLE;
                    end
                end
                default: state_q <= SRCH_IDLE;
            endcase
        end
    end

    assign busy      = running;
    assign found     = found_q;
    assign found_key = fkey_q;
    assign exhausted = exh_q;

endmodule

// File: rtl/keyrange_search_chk.sv
module keyrange_search_chk #(
    parameter int unsigned KEY_W       = 16,
    parameter int unsigned NUM_WORKERS = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   go,
    input logic                   clr,
    input logic [KEY_W-1:0]       start_key,
    input logic [KEY_W-1:0]       end_key,
    input logic [NUM_WORKERS-1:0] wk_start,
    input logic [KEY_W-1:0]       wk_key,
    input logic                   busy,
    input logic                   found,
    input logic [KEY_W-1:0]       found_key,
    input logic                   exhausted
);

    AST_ONE_START: assert property (@(posedge clk) disable iff (rst) $onehot0(wk_start)); // R3
    AST_KEY_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (|wk_start) |-> (wk_key >= start_key && wk_key <= end_key)); // R2
    AST_HALT_ON_FOUND: assert property (@(posedge clk) disable iff (rst) found |-> (wk_start == '0)); // R6
    AST_FOUND_HELD: assert property (@(posedge clk) disable iff (rst)
        (found && !clr && !go) |=> (found && $stable(found_key))); // R6
    AST_FLAGS_APART: assert property (@(posedge clk) disable iff (rst) !(found && exhausted)); // R7
    AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (rst) !busy |-> (wk_start == '0)); // R9

endmodule

bind keyrange_search keyrange_search_chk #(
    .KEY_W       (KEY_W),
    .NUM_WORKERS (NUM_WORKERS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .clr       (clr),
    .start_key (start_key),
    .end_key   (end_key),
    .wk_start  (wk_start),
    .wk_key    (wk_key),
    .busy      (busy),
    .found     (found),
    .found_key (found_key),
    .exhausted (exhausted)
);

// File: tb/keyrange_search_tb.sv
module keyrange_search_tb;

    localparam int KW = 16;
    localparam int SW = 16;
    localparam int NW = 4;
    localparam logic [SW-1:0] CIPHER = 16'h5F2E;
    localparam logic [SW-1:0] HEADER = 16'h9C8B;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic go = 1'b0, clr = 1'b0;
    logic [KW-1:0] start_key = '0, end_key = '0;
    logic [SW-1:0] target;
    logic [NW-1:0] wk_start, wk_done;
    logic [KW-1:0] wk_key, found_key;
    logic [NW*SW-1:0] wk_stream;
    logic busy, found, exhausted;

    int total = 0, bad = 0;
    logic [KW-1:0] plant [3];
    logic plant_en [3];
    int mon_cnt = 0, mon_err = 0, late_starts = 0;
    logic [KW-1:0] mon_base = '0;

    assign target = CIPHER ^ HEADER;

    always #4 clk = ~clk;

    keyrange_search #(.KEY_W(KW), .STREAM_W(SW), .NUM_WORKERS(NW)) u_dut (
        .clk(clk), .rst(rst), .go(go), .clr(clr), .start_key(start_key),
        .end_key(end_key), .target(target), .wk_start(wk_start), .wk_key(wk_key),
        .wk_done(wk_done), .wk_stream(wk_stream), .busy(busy), .found(found),
        .found_key(found_key), .exhausted(exhausted));

    function automatic logic is_planted(input logic [KW-1:0] k);
        for (int p = 0; p < 3; p++) if (plant_en[p] && plant[p] == k) return 1'b1;
        return 1'b0;
    endfunction

    // Behavioural workers: worker g answers 8-g cycles after its strobe.
    for (genvar g = 0; g < NW; g++) begin : g_stub
        logic [7:0] cnt;
        logic [KW-1:0] k;
        logic d;
        logic [SW-1:0] s;
        always @(posedge clk) begin
            if (rst) begin
                cnt <= '0; d <= 1'b0; s <= '0; k <= '0;
            end else begin
                d <= 1'b0;
                if (wk_start[g]) begin
                    cnt <= 8'(8 - g);
                    k   <= wk_key;
                end else if (cnt != 0) begin
                    cnt <= cnt - 1'b1;
                    if (cnt == 8'd1) begin
                        d <= 1'b1;
                        s <= is_planted(k) ? target : ~target;
                    end
                end
            end
        end
        assign wk_done[g] = d;
        assign wk_stream[g*SW +: SW] = s;
    end

    // Dispatch monitor (R2, R3, R6)
    always @(negedge clk) begin
        if (!rst && wk_start != '0) begin
            if (found) late_starts++;
            if (wk_start != (NW'(1) << (mon_cnt % NW)) || wk_key != mon_base + KW'(mon_cnt)) begin
                mon_err++;
                $display("FAIL R3 dispatch %0d: start=%b key=%0d expected start=%b key=%0d",
                         mon_cnt, wk_start, wk_key, NW'(1) << (mon_cnt % NW), mon_base + KW'(mon_cnt));
            end
            mon_cnt++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_search(input logic [KW-1:0] s, input logic [KW-1:0] e, input bit poke_go);
        int n;
        @(negedge clk);
        start_key = s; end_key = e;
        mon_base = s; mon_cnt = 0; mon_err = 0; late_starts = 0;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        check("R9 busy after go", busy, 1);
        n = 0;
        while (!found && !exhausted && n < 5000) begin
            if (poke_go && n == 10) go = 1'b1;
            @(negedge clk);
            go = 1'b0;
            n++;
        end
        if (n >= 5000) check("watchdog", 0, 1);
        check("R9 busy drops at result", busy, 0);
        check("R7 flags apart", found && exhausted, 0);
    endtask

    task automatic finish_search();
        repeat (20) @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R8 clr clears found", found, 0);
        check("R8 clr clears exhausted", exhausted, 0);
    endtask

    task automatic t_reset();
        check("R1 found at reset", found, 0);
        check("R1 exhausted at reset", exhausted, 0);
        check("R1 busy at reset", busy, 0);
        check("R1 no start at reset", wk_start, 0);
    endtask

    task automatic t_plant(input logic [KW-1:0] s, input logic [KW-1:0] e, input logic [KW-1:0] k, input string where);
        plant[0] = k; plant_en[0] = 1'b1; plant_en[1] = 1'b0; plant_en[2] = 1'b0;
        run_search(s, e, 1'b0);
        check({"R4 found ", where}, found, 1);
        check({"R4 key ", where}, found_key, k);
        check({"R3 order ", where}, mon_err, 0);
        repeat (20) @(negedge clk);
        check({"R6 found held ", where}, found, 1);
        check({"R6 no starts after found ", where}, late_starts, 0);
        finish_search();
    endtask

    task automatic t_priority();
        plant[0] = 16'd300; plant[1] = 16'd301; plant[2] = 16'd320;
        plant_en[0] = 1'b1; plant_en[1] = 1'b1; plant_en[2] = 1'b1;
        run_search(16'd300, 16'd340, 1'b0);
        check("R5 lowest worker wins", found_key, 16'd300);
        repeat (30) @(negedge clk);
        check("R6 later match ignored", found_key, 16'd300);
        check("R6 no starts after found", late_starts, 0);
        finish_search();
    endtask

    task automatic t_none(input logic [KW-1:0] s, input logic [KW-1:0] e, input bit poke_go);
        plant_en[0] = 1'b0; plant_en[1] = 1'b0; plant_en[2] = 1'b0;
        run_search(s, e, poke_go);
        check("R7 exhausted", exhausted, 1);
        check("R7 found low", found, 0);
        check("R2 every key once", mon_cnt, int'(e - s) + 1);
        check("R3 order in empty range", mon_err, 0);
        if (poke_go) check("R8 go while busy ignored", mon_err, 0);
        finish_search();
    endtask

    initial begin
        plant_en[0] = 1'b0; plant_en[1] = 1'b0; plant_en[2] = 1'b0;
        plant[0] = '0; plant[1] = '0; plant[2] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plant(16'd100, 16'd160, 16'd100, "at start");
        t_plant(16'd100, 16'd160, 16'd131, "in middle");
        t_plant(16'd100, 16'd160, 16'd160, "at end");
        t_priority();
        t_none(16'd500, 16'd530, 1'b1);
        t_none(16'd777, 16'd777, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule